// File: doc/BRIEF.md
# LDPC Iteration Termination Controller

This block is the sequencing and stopping logic of an iterative layered LDPC decoder. A frame begins with a one-cycle start strobe, which carries the frame-length flag, the code-rate index, the requested number of iterations, the stopping mode and the number of layers in the selected code. The block waits until the channel values are loaded. It then steps through every layer of the code once per iteration, and after each iteration it samples the parity result that the check-node datapath supplies. Using that result, it decides whether to run another iteration or to finish.

Two stopping modes are available. The fixed mode always runs the requested count. The early mode stops at the first iteration whose parity result shows that every check is satisfied, and otherwise stops at the requested count. When the block finishes, it holds the final parity status and the number of iterations it performed, and it pulses a done strobe. A ready flag marks the cycle in which a new frame can be taken. A start that arrives while the block is busy abandons the current frame and restarts the block with the new parameters. An illegal configuration is rejected and flagged without any decoding.

Top module: `ldpc_term_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, `ready` is 1 and `layerReq`, `decodeDone`, `cfgErr`, `iterUsed` and `parityPass` are 0. `ready` is 0 from the cycle after an accepted legal start until the cycle after `decodeDone`.
- R2: A start with `rateIdx` above 10, with `shortFrame`=1 together with `rateIdx`=10, or with `numLayers`=0 is rejected. `cfgErr` is 1 for exactly the one cycle after that start, the block stays (or returns) idle with `ready`=1, and no layer is requested.
- R3: A requested iteration count of 0 or of 64 and above is replaced by 8. A count from 1 to 63 is used unchanged.
- R4: While decoding, `layerReq` is 1 and `layerIdx` counts 0, 1, … up to `numLayers`-1 in order. It advances only in a cycle where `layerAck` is 1, and it holds its value while `layerAck` is 0.
- R5: With `earlyMode`=0, exactly the (sanitized) requested number of iterations is run, whatever `parityOk` reports.
- R6: With `earlyMode`=1, decoding stops after the first iteration for which `parityOk` is 1, or after the requested count if that comes first.
- R7: At `decodeDone`, `parityPass` equals the `parityOk` value sampled after the last iteration (1 pass, 0 fail), and `iterUsed` equals the number of iterations performed. Both hold until the next start.
- R8: `decodeDone` is a one-cycle pulse. The following cycle has `ready`=1.
- R9: A start while `ready`=0 abandons the frame in progress. The layer counter, the iteration counter, the results and the latched parameters are cleared, and the new frame is decoded from layer 0 and iteration 0 with its own parameters.
- R10: After an accepted start, no layer is requested until `loadDone` has been seen high.
- R11: `iterIdx` gives the zero-based number of the iteration in progress. `parityOk` is sampled in the single check cycle that follows the acknowledge of the last layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | One-cycle frame start strobe |
| shortFrame | input | 1 | Frame length flag: 0 normal, 1 short |
| rateIdx | input | 4 | Code-rate index, legal 0..10 (10 not with short frames) |
| iterReq | input | 8 | Requested iteration count |
| earlyMode | input | 1 | 1 stops early when all checks pass, 0 runs the full count |
| numLayers | input | LAYER_W | Layers per iteration for the selected code |
| loadDone | input | 1 | Channel values are loaded |
| layerAck | input | 1 | Datapath finished the requested layer |
| parityOk | input | 1 | All parity checks satisfied after the iteration |
| ready | output | 1 | Next frame start can be accepted |
| cfgErr | output | 1 | One-cycle pulse for a rejected configuration |
| layerReq | output | 1 | Datapath should process layer `layerIdx` |
| layerIdx | output | LAYER_W | Current layer |
| iterIdx | output | CNT_W | Current iteration, zero-based |
| decodeDone | output | 1 | One-cycle end-of-decode pulse |
| parityPass | output | 1 | Final parity status |
| iterUsed | output | CNT_W | Iterations performed |

## Verification
The bench uses the default parameters. These are an iteration ceiling of 63, a substitute count of 8 and an 8-bit layer count, so a request of exactly 63 runs to completion, and requests of 0, 64, 70 and 255 all collapse to 8 within a short run. The small layer counts (1 to 4) let the bench drive frames that use the full iteration budget as well as frames that stop early. The bench also covers a throttled acknowledge, a long load phase, and a restart in the middle of decoding followed by a second frame.

// File: rtl/ldpc_term_pkg.sv
package ldpc_term_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DECODE,
    ST_CHECK,
    ST_OUTPUT
  } ctrlState_t;

  // Strobes from the sequencer to the counter/latch datapath
  typedef struct packed {
    logic clearAll;     // any start: wipe counters and results
    logic latchCfg;     // legal start: capture frame parameters
    logic layerStep;    // advance layer counter
    logic layerWrap;    // last layer acknowledged: back to layer 0
    logic iterStep;     // another iteration follows
    logic latchResult;  // stop decision taken: capture results
  } dpCtl_t;

endpackage

// File: rtl/ldpc_term_dp.sv
module ldpc_term_dp
  import ldpc_term_pkg::*;
#(
  parameter int ITER_W       = 8,
  parameter int ITER_MAX     = 63,
  parameter int ITER_DEFAULT = 8,
  parameter int LAYER_W      = 8,
  parameter int RATE_W       = 4,
  parameter int RATE_MAX     = 10,
  parameter int SHORT_BAR    = 10,
  localparam int CNT_W       = $clog2(ITER_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic               shortFrame,
  input  logic [RATE_W-1:0]  rateIdx,
  input  logic [ITER_W-1:0]  iterReq,
  input  logic               earlyMode,
  input  logic [LAYER_W-1:0] numLayers,
  input  logic               parityOk,
  output logic               cfgLegal,
  output logic               lastLayer,
  output logic               stopNow,
  output logic [LAYER_W-1:0] layerIdx,
  output logic [CNT_W-1:0]   iterIdx,
  output logic [CNT_W-1:0]   iterUsed,
  output logic               parityPass
);

  logic               cfgEarly;
  logic [LAYER_W-1:0] cfgLayers;
  logic [CNT_W-1:0]   iterLimit;
  logic [LAYER_W-1:0] layerCnt;
  logic [CNT_W-1:0]   iterCnt;
  logic [CNT_W-1:0]   iterUsedQ;
  logic               passQ;
  logic               reqInRange;
  logic [CNT_W-1:0]   iterSan;
  logic [CNT_W-1:0]   iterNext;

  // Configuration legality, judged on the start cycle inputs
  always_comb begin
    cfgLegal = 1'b1;
    if (rateIdx > RATE_W'(RATE_MAX))                   cfgLegal = 1'b0;
    if (shortFrame && (rateIdx == RATE_W'(SHORT_BAR))) cfgLegal = 1'b0;
    if (numLayers == '0)                               cfgLegal = 1'b0;
  end

  // Iteration request sanitizing: out-of-range requests use the default
  assign reqInRange = (iterReq != '0) && (iterReq <= ITER_W'(ITER_MAX));
  assign iterSan    = reqInRange ? iterReq[CNT_W-1:0] : CNT_W'(ITER_DEFAULT);

  // Latched frame parameters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEarly  <= 1'b0;
      cfgLayers <= '0;
      iterLimit <= '0;
    end else if (ctl.clearAll) begin
      if (ctl.latchCfg) begin
        cfgEarly  <= earlyMode;
        cfgLayers <= numLayers;
        iterLimit <= iterSan;
      end else begin
        cfgEarly  <= 1'b0;
        cfgLayers <= '0;
        iterLimit <= '0;
      end
    end
  end

  // Layer counter nested inside the iteration counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      layerCnt <= '0;
    end else if (ctl.clearAll || ctl.layerWrap) begin
      layerCnt <= '0;
    end else if (ctl.layerStep) begin
      layerCnt <= layerCnt + LAYER_W'(1);
    end
  end

  assign iterNext = iterCnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iterCnt <= '0;
    end else if (ctl.clearAll) begin
      iterCnt <= '0;
    end else if (ctl.iterStep) begin
      iterCnt <= iterNext;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iterUsedQ <= '0;
      passQ     <= 1'b0;
    end else if (ctl.clearAll) begin
      iterUsedQ <= '0;
      passQ     <= 1'b0;
    end else if (ctl.latchResult) begin
      iterUsedQ <= iterNext;
      passQ     <= parityOk;
    end
  end

  assign lastLayer  = (layerCnt == (cfgLayers - LAYER_W'(1)));
  assign stopNow    = (cfgEarly && parityOk) || (iterNext == iterLimit);
  assign layerIdx   = layerCnt;
  assign iterIdx    = iterCnt;
  assign iterUsed   = iterUsedQ;
  assign parityPass = passQ;

endmodule

// File: rtl/ldpc_term_fsm.sv
module ldpc_term_fsm
  import ldpc_term_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   frameStart,
  input  logic   cfgLegal,
  input  logic   loadDone,
  input  logic   layerAck,
  input  logic   lastLayer,
  input  logic   stopNow,
  output dpCtl_t ctl,
  output logic   ready,
  output logic   layerReq,
  output logic   decodeDone,
  output logic   cfgErr
);

  ctrlState_t state;
  ctrlState_t nextState;
  logic       cfgErrD;
  logic       cfgErrQ;

  always_comb begin
    nextState = state;
    ctl       = '0;
    cfgErrD   = 1'b0;
    if (frameStart) begin
      // Accepted in every state; a busy frame is abandoned
      ctl.clearAll = 1'b1;
      ctl.latchCfg = cfgLegal;
      cfgErrD      = !cfgLegal;
      nextState    = cfgLegal ? ST_LOAD : ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   nextState = ST_IDLE;
        ST_LOAD:   if (loadDone) nextState = ST_DECODE;
        ST_DECODE: begin
          if (layerAck) begin
            ctl.layerStep = 1'b1;
            if (lastLayer) begin
              ctl.layerWrap = 1'b1;
              nextState     = ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (stopNow) begin
            ctl.latchResult = 1'b1;
            nextState       = ST_OUTPUT;
          end else begin
            ctl.iterStep = 1'b1;
            nextState    = ST_DECODE;
          end
        end
        ST_OUTPUT: nextState = ST_IDLE;
        default:   nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cfgErrQ <= 1'b0;
    end else begin
      state   <= nextState;
      cfgErrQ <= cfgErrD;
    end
  end

  assign ready      = (state == ST_IDLE);
  assign layerReq   = (state == ST_DECODE);
  assign decodeDone = (state == ST_OUTPUT);
  assign cfgErr     = cfgErrQ;

endmodule

// File: rtl/ldpc_term_ctrl.sv
module ldpc_term_ctrl
  import ldpc_term_pkg::*;
#(
  parameter int ITER_W       = 8,
  parameter int ITER_MAX     = 63,
  parameter int ITER_DEFAULT = 8,
  parameter int LAYER_W      = 8,
  parameter int RATE_W       = 4,
  parameter int RATE_MAX     = 10,
  parameter int SHORT_BAR    = 10,
  localparam int CNT_W       = $clog2(ITER_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               shortFrame,
  input  logic [RATE_W-1:0]  rateIdx,
  input  logic [ITER_W-1:0]  iterReq,
  input  logic               earlyMode,
  input  logic [LAYER_W-1:0] numLayers,
  input  logic               loadDone,
  input  logic               layerAck,
  input  logic               parityOk,
  output logic               ready,
  output logic               cfgErr,
  output logic               layerReq,
  output logic [LAYER_W-1:0] layerIdx,
  output logic [CNT_W-1:0]   iterIdx,
  output logic               decodeDone,
  output logic               parityPass,
  output logic [CNT_W-1:0]   iterUsed
);

  dpCtl_t ctl;
  logic   cfgLegal;
  logic   lastLayer;
  logic   stopNow;

  ldpc_term_fsm uFsm (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .cfgLegal   (cfgLegal),
    .loadDone   (loadDone),
    .layerAck   (layerAck),
    .lastLayer  (lastLayer),
    .stopNow    (stopNow),
    .ctl        (ctl),
    .ready      (ready),
    .layerReq   (layerReq),
    .decodeDone (decodeDone),
    .cfgErr     (cfgErr)
  );

  ldpc_term_dp #(
    .ITER_W       (ITER_W),
    .ITER_MAX     (ITER_MAX),
    .ITER_DEFAULT (ITER_DEFAULT),
    .LAYER_W      (LAYER_W),
    .RATE_W       (RATE_W),
    .RATE_MAX     (RATE_MAX),
    .SHORT_BAR    (SHORT_BAR)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .shortFrame (shortFrame),
    .rateIdx    (rateIdx),
    .iterReq    (iterReq),
    .earlyMode  (earlyMode),
    .numLayers  (numLayers),
    .parityOk   (parityOk),
    .cfgLegal   (cfgLegal),
    .lastLayer  (lastLayer),
    .stopNow    (stopNow),
    .layerIdx   (layerIdx),
    .iterIdx    (iterIdx),
    .iterUsed   (iterUsed),
    .parityPass (parityPass)
  );

endmodule

// File: rtl/ldpc_term_chk.sv
module ldpc_term_chk #(
  parameter int LAYER_W  = 8,
  parameter int ITER_MAX = 63,
  localparam int CNT_W   = $clog2(ITER_MAX + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameStart,
  input logic               layerAck,
  input logic               ready,
  input logic               cfgErr,
  input logic               layerReq,
  input logic [LAYER_W-1:0] layerIdx,
  input logic               decodeDone,
  input logic [CNT_W-1:0]   iterUsed
);

  AST_ERR_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $past(frameStart)); // R2

  AST_ERR_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (ready && !layerReq)); // R2

  AST_LAYER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (layerReq && !layerAck && !frameStart) |=> (layerReq && $stable(layerIdx))); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (decodeDone && !frameStart) |=> (!decodeDone && ready)); // R8

  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    decodeDone |-> ((iterUsed != '0) && (iterUsed <= CNT_W'(ITER_MAX)))); // R3

  AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !ready) |=> !layerReq); // R9

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(frameStart)); // R1

endmodule

bind ldpc_term_ctrl ldpc_term_chk #(
  .LAYER_W  (LAYER_W),
  .ITER_MAX (ITER_MAX)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .layerAck   (layerAck),
  .ready      (ready),
  .cfgErr     (cfgErr),
  .layerReq   (layerReq),
  .layerIdx   (layerIdx),
  .decodeDone (decodeDone),
  .iterUsed   (iterUsed)
);

// File: tb/tb_ldpc_term_ctrl.sv
module tb_ldpc_term_ctrl;

  localparam int LAYER_W = 8;
  localparam int CNT_W   = 6;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               frameStart = 1'b0;
  logic               shortFrame = 1'b0;
  logic [3:0]         rateIdx = '0;
  logic [7:0]         iterReq = '0;
  logic               earlyMode = 1'b0;
  logic [LAYER_W-1:0] numLayers = '0;
  logic               loadDone = 1'b0;
  logic               layerAck = 1'b0;
  logic               parityOk = 1'b0;
  logic               ready;
  logic               cfgErr;
  logic               layerReq;
  logic [LAYER_W-1:0] layerIdx;
  logic [CNT_W-1:0]   iterIdx;
  logic               decodeDone;
  logic               parityPass;
  logic [CNT_W-1:0]   iterUsed;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic stallAck = 1'b0;

  always #2.5 clk = ~clk;

  ldpc_term_ctrl dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .shortFrame(shortFrame),
    .rateIdx(rateIdx), .iterReq(iterReq), .earlyMode(earlyMode),
    .numLayers(numLayers), .loadDone(loadDone), .layerAck(layerAck),
    .parityOk(parityOk), .ready(ready), .cfgErr(cfgErr), .layerReq(layerReq),
    .layerIdx(layerIdx), .iterIdx(iterIdx), .decodeDone(decodeDone),
    .parityPass(parityPass), .iterUsed(iterUsed)
  );

  typedef struct packed {
    logic       sf;
    logic [3:0] rate;
    logic [7:0] iter;
    logic       early;
    logic [7:0] layers;
    logic [15:0] pat;     // bit k = parityOk after iteration k
    logic [5:0] expUsed;
    logic       expPass;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'd3,  8'd4,   1'b0, 8'd3, 16'h0001, 6'd4,  1'b0}, // R5 max ignores early pass
    '{1'b0, 4'd5,  8'd4,   1'b1, 8'd2, 16'h0004, 6'd3,  1'b1}, // R6 early stop
    '{1'b1, 4'd2,  8'd0,   1'b0, 8'd2, 16'h0080, 6'd8,  1'b1}, // R3 zero -> 8
    '{1'b0, 4'd9,  8'd70,  1'b1, 8'd1, 16'h0000, 6'd8,  1'b0}, // R3 70 -> 8, R6 limit
    '{1'b1, 4'd9,  8'd1,   1'b1, 8'd4, 16'h0001, 6'd1,  1'b1}, // R6 first iteration
    '{1'b0, 4'd10, 8'd63,  1'b0, 8'd1, 16'h0000, 6'd63, 1'b0}, // R3 upper bound kept
    '{1'b0, 4'd0,  8'd5,   1'b1, 8'd3, 16'h0010, 6'd5,  1'b1}, // R6 pass on last allowed
    '{1'b1, 4'd7,  8'd64,  1'b1, 8'd2, 16'h0002, 6'd2,  1'b1}, // R3 64 -> 8
    '{1'b0, 4'd1,  8'd255, 1'b0, 8'd3, 16'h0000, 6'd8,  1'b0}  // R3 255 -> 8
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      summary();
    end
  end

  task automatic startFrame(input logic sf, input logic [3:0] rate, input logic [7:0] it,
                            input logic early, input logic [7:0] layers);
    frameStart = 1'b1;
    shortFrame = sf;
    rateIdx    = rate;
    iterReq    = it;
    earlyMode  = early;
    numLayers  = layers;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // Called at the negedge right after the start strobe was removed
  task automatic runToDone(input int layers, input logic [15:0] pat,
                           input int expUsed, input logic expPass, input string tag);
    int expLayer = 0;
    int acks = 0;
    int guard = 0;
    int cyc = 0;
    bit layerBad = 0;
    loadDone = 1'b1;
    while (!decodeDone && guard < 4000) begin
      if (layerReq && (int'(layerIdx) != expLayer)) layerBad = 1;
      parityOk = (int'(iterIdx) < 16) ? pat[iterIdx] : 1'b0;
      layerAck = stallAck ? cyc[0] : 1'b1;
      if (layerReq && layerAck) begin
        acks++;
        expLayer = (expLayer + 1) % layers;
      end
      cyc++;
      guard++;
      @(negedge clk);
    end
    layerAck = 1'b0;
    loadDone = 1'b0;
    check(decodeDone == 1'b1, "R8", {tag, " done seen"}, decodeDone, 1);
    check(!layerBad, "R4", {tag, " layer order"}, layerBad, 0);
    check(acks == expUsed * layers, "R4", {tag, " layers processed"}, acks, expUsed * layers);
    check(int'(iterUsed) == expUsed, "R7", {tag, " iterUsed"}, iterUsed, expUsed);
    check(parityPass == expPass, "R7", {tag, " parityPass"}, parityPass, expPass);
    @(negedge clk);
    check(!decodeDone && ready, "R8", {tag, " pulse end"}, {decodeDone, ready}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ready && !layerReq && !decodeDone && !cfgErr && iterUsed == 0 && !parityPass,
          "R1", "reset outputs", {ready, layerReq, decodeDone, cfgErr}, 8);
    rstN = 1'b1;
    @(negedge clk);

    // Table of frames
    for (int i = 0; i < NVEC; i++) begin
      startFrame(VECS[i].sf, VECS[i].rate, VECS[i].iter, VECS[i].early, VECS[i].layers);
      check(!ready, "R1", $sformatf("vec%0d busy after start", i), ready, 0);
      runToDone(int'(VECS[i].layers), VECS[i].pat, int'(VECS[i].expUsed),
                VECS[i].expPass, $sformatf("vec%0d", i));
    end

    // R2: short frame with rate index 10
    startFrame(1'b1, 4'd10, 8'd4, 1'b0, 8'd2);
    check(cfgErr && ready && !layerReq, "R2", "short+rate10 reject",
          {cfgErr, ready, layerReq}, 6);
    @(negedge clk);
    check(!cfgErr && ready && !layerReq, "R2", "error one cycle", {cfgErr, ready, layerReq}, 2);

    // R2: rate index out of range
    startFrame(1'b0, 4'd11, 8'd4, 1'b0, 8'd2);
    check(cfgErr && ready, "R2", "rate11 reject", {cfgErr, ready}, 3);
    // R2: zero layers
    @(negedge clk);
    startFrame(1'b0, 4'd3, 8'd4, 1'b0, 8'd0);
    check(cfgErr && ready, "R2", "zero layers reject", {cfgErr, ready}, 3);
    @(negedge clk);

    // R10: LOAD waits for loadDone; R4 with throttled acknowledge
    startFrame(1'b0, 4'd4, 8'd2, 1'b0, 8'd3);
    repeat (4) @(negedge clk);
    check(!layerReq && !ready, "R10", "waiting for load", {layerReq, ready}, 0);
    stallAck = 1'b1;
    runToDone(3, 16'h0002, 2, 1'b1, "stall");
    stallAck = 1'b0;

    // R9: restart mid-decode
    startFrame(1'b0, 4'd6, 8'd8, 1'b0, 8'd2);
    loadDone = 1'b1;
    layerAck = 1'b1;
    repeat (5) @(negedge clk);
    check(!ready && int'(iterIdx) >= 1, "R11", "first frame advanced", iterIdx, 1);
    layerAck = 1'b0;
    loadDone = 1'b0;
    startFrame(1'b1, 4'd1, 8'd2, 1'b0, 8'd3);
    check(!layerReq && iterIdx == 0 && layerIdx == 0 && !ready, "R9", "counters cleared",
          {iterIdx, layerIdx}, 0);
    runToDone(3, 16'h0002, 2, 1'b1, "restart");

    // R9: restart with an illegal configuration drops to idle
    startFrame(1'b0, 4'd2, 8'd8, 1'b0, 8'd2);
    loadDone = 1'b1;
    layerAck = 1'b1;
    repeat (3) @(negedge clk);
    layerAck = 1'b0;
    loadDone = 1'b0;
    startFrame(1'b1, 4'd10, 8'd2, 1'b0, 8'd3);
    check(cfgErr && ready && !layerReq && iterUsed == 0, "R9", "abandon to idle",
          {cfgErr, ready, layerReq}, 6);

    summary();
  end

endmodule